// File: doc/BRIEF.md
# Two-Class Interrupt Holdoff Timer

This block merges bursts of device events into a small number of processor interrupts. Each event belongs to one of two classes, and software chooses which class it uses. Every class has its own pending flag and its own 16-bit holdoff down-counter. An event sets the pending flag of its class. The interrupt line rises only after that class's counter has run out. Events that arrive during the countdown are folded into the pending flag that is already set.

A service routine normally works in three steps. It reads the cause register, which returns both pending flags and clears them. It handles the events it found. It then writes the class delay registers, which reloads each counter and holds off the next batch for the chosen number of cycles. A class can be masked so that it never drives the interrupt line. Its events are still recorded in the cause register.

Top module: `irq_coalesce`

## Requirements
- R1: After reset, `irq_o` is 0, `cause_o` is 0 and both holdoff counters are at zero.
- R2: A 1 on `evt_i[c]` at a clock edge sets pending bit `c` (bit 0 is class 0, bit 1 is class 1), and `cause_o` shows it after that edge. Further events on the same class keep the single bit set.
- R3: When `dly_we_i[c]` is 1 at an edge, counter `c` is loaded with `dly_wdata_i` at that edge. It then drops by one on each later edge and stays at zero instead of wrapping.
- R4: `irq_o` is 1 exactly when at least one class is pending, unmasked and has its counter at zero. Events taken in while a counter is nonzero do not raise `irq_o`.
- R5: When a class's counter is zero (a delay of zero), an unmasked event on that class raises `irq_o` in the cycle that follows the event's edge.
- R6: While `mask_i[c]` is 1, class `c` never raises `irq_o`, but its events still set its cause bit. Clearing the mask with the class pending and expired raises `irq_o` in the same cycle.
- R7: A 1 on `cause_rd_i` at an edge clears the pending bits that `cause_o` showed in that cycle. A class whose event arrives at that same edge stays pending.
- R8: The two classes time out on their own. Writing one class's delay register does not change the other class's counter.
- R9: Writing a delay register while its counter is running restarts the countdown from the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_CLASSES | One-cycle event strobe for each class |
| mask_i | input | NUM_CLASSES | 1 blocks the class from driving the interrupt |
| dly_we_i | input | NUM_CLASSES | Write strobe for each class's delay register |
| dly_wdata_i | input | CNT_W | Delay value, in cycles, for the write |
| cause_rd_i | input | 1 | Cause register read strobe; clears the returned bits |
| cause_o | output | NUM_CLASSES | Pending bits of both classes |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A counter that is off by one moves the rise of `irq_o` by one cycle compared with the cycle the delay write predicts, so each countdown is checked at every cycle from the load to expiry and past it. A pending bit that is cleared at the wrong time, or that misses a strobe arriving with a read, shows up on `cause_o` in the next cycle and then as a missing or extra interrupt. A mask that is applied to the wrong class raises `irq_o` in the same cycle that the mask value is presented.

// File: rtl/irq_hold_pkg.sv
package irq_hold_pkg;

  localparam int unsigned DEF_CLASSES = 2;
  localparam int unsigned DEF_CNT_W   = 16;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_LOAD = 2'd1,
    CNT_DEC  = 2'd2
  } cnt_action_e;

endpackage

// File: rtl/holdoff_counter.sv
module holdoff_counter #(
  parameter int unsigned CNT_W = irq_hold_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  import irq_hold_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  cnt_action_e      action;

  function automatic cnt_action_e pick_action(input logic ld, input logic [CNT_W-1:0] cur);
    if (ld)            return CNT_LOAD;
    else if (cur != '0) return CNT_DEC;
    else               return CNT_HOLD;
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input cnt_action_e act,
                                                  input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] val);
    case (act)
      CNT_LOAD: return val;
      CNT_DEC:  return cur - 1'b1;
      default:  return cur;
    endcase
  endfunction

  assign action = pick_action(load_i, cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_count(action, cnt_q, load_val_i);
  end

  assign expired_o = (cnt_q == '0);

  // R3: load takes the written value at the write edge
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));

  // R3: one step down per cycle while running
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R3: stays at zero, no wrap
  a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && expired_o) |=> expired_o);

endmodule

// File: rtl/pending_latch.sv
module pending_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  output logic pend_o
);

  logic pend_q;

  function automatic logic next_pend(input logic cur, input logic ev, input logic clr);
    return (cur & ~clr) | ev;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= next_pend(pend_q, evt_i, clr_i);
  end

  assign pend_o = pend_q;

  // R2: an event always leaves the class pending
  a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> pend_q);

  // R2: pending is kept until read
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_i) |=> pend_q);

  // R7: a read without a new event clears the bit
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !evt_i) |=> !pend_q);

endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce #(
  parameter int unsigned NUM_CLASSES = irq_hold_pkg::DEF_CLASSES,
  parameter int unsigned CNT_W       = irq_hold_pkg::DEF_CNT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CLASSES-1:0] evt_i,
  input  logic [NUM_CLASSES-1:0] mask_i,
  input  logic [NUM_CLASSES-1:0] dly_we_i,
  input  logic [CNT_W-1:0]       dly_wdata_i,
  input  logic                   cause_rd_i,
  output logic [NUM_CLASSES-1:0] cause_o,
  output logic                   irq_o
);

  logic [NUM_CLASSES-1:0] pend_w;
  logic [NUM_CLASSES-1:0] expired_w;
  logic [NUM_CLASSES-1:0] ready_w;

  function automatic logic [NUM_CLASSES-1:0] class_ready(input logic [NUM_CLASSES-1:0] p,
                                                         input logic [NUM_CLASSES-1:0] m,
                                                         input logic [NUM_CLASSES-1:0] e);
    return p & ~m & e;
  endfunction

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
    holdoff_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (dly_we_i[c]),
      .load_val_i (dly_wdata_i),
      .expired_o  (expired_w[c])
    );

    pending_latch i_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i[c]),
      .clr_i  (cause_rd_i),
      .pend_o (pend_w[c])
    );
  end

  assign ready_w = class_ready(pend_w, mask_i, expired_w);
  assign irq_o   = |ready_w;
  assign cause_o = pend_w;

  // R6: full masking silences the line
  a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_i) |-> !irq_o);

  // R4: the line is never up while every pending class is still counting
  a_r4_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(pend_w & expired_w)));

  // R1: nothing is pending right after reset leaves
  a_r1_clean_start: assert property (@(posedge clk)
    $rose(rst_n) |-> (cause_o == '0));

endmodule

// File: tb/test_irq_coalesce.sv
`timescale 1ns/1ps
module test_irq_coalesce;

  localparam int NC = 2;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] evt_i = '0;
  logic [NC-1:0] mask_i = '0;
  logic [NC-1:0] dly_we_i = '0;
  logic [CW-1:0] dly_wdata_i = '0;
  logic          cause_rd_i = 1'b0;
  logic [NC-1:0] cause_o;
  logic          irq_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  irq_coalesce #(.NUM_CLASSES(NC), .CNT_W(CW)) i_irq_coalesce (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .mask_i(mask_i),
    .dly_we_i(dly_we_i), .dly_wdata_i(dly_wdata_i), .cause_rd_i(cause_rd_i),
    .cause_o(cause_o), .irq_o(irq_o)
  );

  // vector: evt[25:24] mask[23:22] we[21:20] wdata[19:4] rd[3] irq[2] cause[1:0]
  localparam logic [25:0] VEC [20] = '{
    {2'b00, 2'b00, 2'b00, 16'd0, 1'b0, 1'b0, 2'b00}, // R1 idle
    {2'b00, 2'b00, 2'b01, 16'd3, 1'b0, 1'b0, 2'b00}, // R3 load class0 = 3
    {2'b01, 2'b00, 2'b00, 16'd0, 1'b0, 1'b0, 2'b01}, // R4 event while counting
    {2'b01, 2'b00, 2'b00, 16'd0, 1'b0, 1'b0, 2'b01}, // R2 repeat event
    {2'b00, 2'b00, 2'b00, 16'd0, 1'b0, 1'b1, 2'b01}, // R4 expiry raises irq
    {2'b00, 2'b00, 2'b00, 16'd0, 1'b1, 1'b0, 2'b00}, // R7 read clears
    {2'b10, 2'b10, 2'b00, 16'd0, 1'b0, 1'b0, 2'b10}, // R6 masked event recorded
    {2'b00, 2'b10, 2'b00, 16'd0, 1'b0, 1'b0, 2'b10}, // R6 still masked
    {2'b00, 2'b00, 2'b00, 16'd0, 1'b0, 1'b1, 2'b10}, // R6 unmask raises
    {2'b10, 2'b00, 2'b00, 16'd0, 1'b1, 1'b1, 2'b10}, // R7 event with read stays
    {2'b00, 2'b00, 2'b00, 16'd0, 1'b1, 1'b0, 2'b00}, // R7 second read clears
    {2'b00, 2'b00, 2'b11, 16'd2, 1'b0, 1'b0, 2'b00}, // R3 load both = 2
    {2'b11, 2'b00, 2'b00, 16'd0, 1'b0, 1'b0, 2'b11}, // R4 both pending, counting
    {2'b00, 2'b00, 2'b10, 16'd2, 1'b0, 1'b1, 2'b11}, // R8 R9 rearm class1 only
    {2'b00, 2'b00, 2'b00, 16'd0, 1'b1, 1'b0, 2'b00}, // R7 read all
    {2'b10, 2'b00, 2'b00, 16'd0, 1'b0, 1'b1, 2'b10}, // R9 class1 expires on new value
    {2'b00, 2'b00, 2'b00, 16'd0, 1'b1, 1'b0, 2'b00}, // R7 clear
    {2'b01, 2'b01, 2'b00, 16'd0, 1'b0, 1'b0, 2'b01}, // R6 class0 masked
    {2'b00, 2'b00, 2'b00, 16'd0, 1'b0, 1'b1, 2'b01}, // R6 unmask class0
    {2'b00, 2'b00, 2'b00, 16'd0, 1'b1, 1'b0, 2'b00}  // R7 clear
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    evt_i = '0; dly_we_i = '0; dly_wdata_i = '0; cause_rd_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 irq in reset", irq_o, 0);
    check("R1 cause in reset", cause_o, 0);
    rst_n = 1'b1;
    step();
    check("R1 irq after reset", irq_o, 0);
    check("R1 cause after reset", cause_o, 0);

    for (int i = 0; i < 20; i++) begin
      evt_i       = VEC[i][25:24];
      mask_i      = VEC[i][23:22];
      dly_we_i    = VEC[i][21:20];
      dly_wdata_i = VEC[i][19:4];
      cause_rd_i  = VEC[i][3];
      step();
      check($sformatf("R2-table irq vec %0d", i), irq_o, VEC[i][2]);
      check($sformatf("R2-table cause vec %0d", i), cause_o, VEC[i][1:0]);
    end
    idle_inputs();
    mask_i = '0;

    // R5: zero delay, irq on the cycle after the event edge
    evt_i = 2'b01;
    #1;
    check("R5 irq before edge", irq_o, 0);
    step();
    idle_inputs();
    check("R5 irq next cycle", irq_o, 1);
    cause_rd_i = 1'b1;
    step();
    idle_inputs();
    check("R7 cleared after R5", cause_o, 0);

    // R3: load 5 together with an event, expiry exactly five edges later
    dly_we_i = 2'b01; dly_wdata_i = 16'd5; evt_i = 2'b01;
    step();
    idle_inputs();
    check("R3 irq at load", irq_o, 0);
    for (int k = 1; k < 5; k++) begin
      step();
      check($sformatf("R3 counting step %0d", k), irq_o, 0);
    end
    step();
    check("R3 expired after 5", irq_o, 1);
    for (int k = 0; k < 3; k++) begin
      step();
      check("R3 stays at zero", irq_o, 1);
    end
    check("R8 class1 untouched", cause_o, 2'b01);
    cause_rd_i = 1'b1;
    step();
    idle_inputs();

    // R1: reset in the middle of activity
    evt_i = 2'b11;
    step();
    idle_inputs();
    rst_n = 1'b0;
    #1;
    check("R1 irq async reset", irq_o, 0);
    check("R1 cause async reset", cause_o, 0);
    step();
    rst_n = 1'b1;
    step();
    check("R1 cause after re-reset", cause_o, 0);

    finish_run();
  end

endmodule